// File: doc/BRIEF.md
# Multicycle 16-bit register-transfer processor

This block is a small processor core that runs one instruction at a time on eight 16-bit general registers. Every transfer travels over one shared 16-bit bus. A four-bit source selector chooses which value drives that bus: a general register, the external data word, or the arithmetic result register. An operand register A and a result register G let the core add or subtract through that single bus in separate steps.

A host presents instruction words on `din` and holds `run` high while the core may proceed. A move-immediate instruction takes its operand from the `din` word in the cycle after the instruction. `done` pulses in the last cycle of every instruction, and the core is then ready for the next instruction word. The bus value and registers R0 and R1 are brought out so a host can watch results.

Top module: `rtp16_core`

## Requirements
- R1: While `rst_n` is low, and in the fetch state after its synchronised release, `r0_q` and `r1_q` read 0, `done` is low and `bus_out` equals `din` (bus select code 8).
- R2: In the fetch state with `run` low, no instruction is taken. `done` stays low, `bus_out` follows `din` and no register changes.
- R3: An instruction word carries the opcode in `din[15:13]`, the Rx index in `din[12:10]` and the Ry index in `din[9:7]`. `din[6:0]` of an instruction word is ignored.
- R4: Move (opcode 001) takes two cycles. In the second cycle `bus_out` shows Ry, `done` is high, and Rx holds the Ry value from the next cycle on.
- R5: Move-immediate (opcode 010) takes two cycles. In the second cycle `bus_out` shows the `din` word of that cycle, `done` is high, and that word is written into Rx.
- R6: Add (opcode 011) takes four cycles: fetch, then Rx on the bus (latched into A), then Ry on the bus (G gets A+Ry), then G on the bus with `done` high and G written into Rx. The sum wraps modulo 2^16.
- R7: Subtract (opcode 100) follows the same four-cycle sequence, with G getting A−Ry modulo 2^16. The most significant opcode bit selects subtraction.
- R8: The instruction is captured only in fetch with `run` high. After that, `din` changes have no effect on the running instruction, except for the data cycle of move-immediate.
- R9: Opcodes 000, 101, 110 and 111 are no-ops. They take two cycles, raise `done` in the second, and change no register.
- R10: At most one register write enable is active in any cycle, and `done` is followed by a return to fetch.
- R11: Bus select codes 0–7 drive R0–R7, code 8 drives `din` and code 9 drives the result register G.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Allows the core to accept an instruction in fetch |
| din | input | 16 | Instruction word or immediate data |
| done | output | 1 | High in the final cycle of each instruction |
| bus_out | output | 16 | Current value on the shared bus |
| r0_q | output | 16 | Contents of register R0 |
| r1_q | output | 16 | Contents of register R1 |

## Verification
Moves and immediates are driven back to back, with different source and target indices and with non-zero low bits in the instruction word. This separates correct field decoding from a shifted or overlapping field. Adds and subtracts are run on operands that wrap past 0xFFFF and below zero, and with Rx equal to Ry, which tells a true A/G staging from one that reads the bus twice or swaps operands. During execution cycles `din` carries changing noise and `run` is dropped at idle, to expose an instruction register that reloads when it should hold. Each no-op opcode is also tried against R0, so that a stray write shows up.

// File: rtl/rtp16_pkg.sv
`timescale 1ns/1ps
package rtp16_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_RSV  = 3'b000,
    OP_MOV  = 3'b001,
    OP_IMM  = 3'b010,
    OP_ADD  = 3'b011,
    OP_SUB  = 3'b100
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_MOV   = 3'd1,
    ST_IMM   = 3'd2,
    ST_LDA   = 3'd3,
    ST_CALC  = 3'd4,
    ST_WB    = 3'd5,
    ST_NOP   = 3'd6
  } state_e;

endpackage

// File: rtl/rtp16_ctrl.sv
`timescale 1ns/1ps
module rtp16_ctrl
  import rtp16_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  run,
  input  logic [OPC_W+2*$clog2(NREG)-1:0]       ins_word,
  output logic [$clog2(NREG+2)-1:0]             bus_sel,
  output logic [NREG-1:0]                       reg_we,
  output logic                                  a_load,
  output logic                                  g_load,
  output logic                                  sub_mode,
  output logic                                  done
);
  localparam int RIDX_W  = $clog2(NREG);
  localparam int IR_W    = OPC_W + 2*RIDX_W;
  localparam int SEL_W   = $clog2(NREG+2);
  localparam logic [SEL_W-1:0] SEL_DIN = SEL_W'(NREG);
  localparam logic [SEL_W-1:0] SEL_RES = SEL_W'(NREG+1);

  state_e            state_q, state_d;
  logic [IR_W-1:0]   ir_q;
  logic              ir_load;
  logic [OPC_W-1:0]  op_new;
  logic [OPC_W-1:0]  op_cur;
  logic [RIDX_W-1:0] rx, ry;

  assign op_new = ins_word[IR_W-1 -: OPC_W];
  assign op_cur = ir_q[IR_W-1 -: OPC_W];
  assign rx     = ir_q[2*RIDX_W-1 -: RIDX_W];
  assign ry     = ir_q[RIDX_W-1:0];

  always_comb begin
    state_d  = state_q;
    bus_sel  = SEL_DIN;
    reg_we   = '0;
    a_load   = 1'b0;
    g_load   = 1'b0;
    sub_mode = op_cur[OPC_W-1];
    done     = 1'b0;
    ir_load  = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        if (run) begin
          ir_load = 1'b1;
          case (op_new)
            OP_MOV:         state_d = ST_MOV;
            OP_IMM:         state_d = ST_IMM;
            OP_ADD, OP_SUB: state_d = ST_LDA;
            default:        state_d = ST_NOP;
          endcase
        end
      end
      ST_MOV: begin
        bus_sel    = SEL_W'(ry);
        reg_we[rx] = 1'b1;
        done       = 1'b1;
        state_d    = ST_FETCH;
      end
      ST_IMM: begin
        bus_sel    = SEL_DIN;
        reg_we[rx] = 1'b1;
        done       = 1'b1;
        state_d    = ST_FETCH;
      end
      ST_LDA: begin
        bus_sel = SEL_W'(rx);
        a_load  = 1'b1;
        state_d = ST_CALC;
      end
      ST_CALC: begin
        bus_sel = SEL_W'(ry);
        g_load  = 1'b1;
        state_d = ST_WB;
      end
      ST_WB: begin
        bus_sel    = SEL_RES;
        reg_we[rx] = 1'b1;
        done       = 1'b1;
        state_d    = ST_FETCH;
      end
      ST_NOP: begin
        done    = 1'b1;
        state_d = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      if (ir_load) ir_q <= ins_word;
    end
  end

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_we)); // R10
  AST_DONE_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state_q == ST_FETCH)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && !run) |=> (state_q == ST_FETCH)); // R2
  AST_IR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_FETCH) |=> $stable(ir_q)); // R8

endmodule

// File: rtl/rtp16_regfile.sv
`timescale 1ns/1ps
module rtp16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          we,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  regs
);
  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs[gi] <= '0;
      else if (we[gi]) regs[gi] <= wdata;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we[gi] |=> (regs[gi] == $past(wdata))); // R4
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !we[gi] |=> $stable(regs[gi])); // R9
  end
endmodule

// File: rtl/rtp16_alu.sv
`timescale 1ns/1ps
module rtp16_alu #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_load,
  input  logic          g_load,
  input  logic          sub_mode,
  input  logic [DW-1:0] bus,
  output logic [DW-1:0] g_q
);
  logic [DW-1:0] a_q;
  logic [DW-1:0] result;

  always_comb begin
    if (sub_mode) result = a_q - bus;
    else          result = a_q + bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      g_q <= '0;
    end else begin
      if (a_load) a_q <= bus;
      if (g_load) g_q <= result;
    end
  end

  AST_A_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !a_load |=> $stable(a_q)); // R6
  AST_G_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !g_load |=> $stable(g_q)); // R7
endmodule

// File: rtl/rtp16_core.sv
`timescale 1ns/1ps
module rtp16_core
  import rtp16_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] din,
  output logic          done,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] r0_q,
  output logic [DW-1:0] r1_q
);
  localparam int RIDX_W = $clog2(NREG);
  localparam int IR_W   = OPC_W + 2*RIDX_W;
  localparam int SEL_W  = $clog2(NREG+2);

  logic [1:0]              rst_sync;
  logic                    rst_int_n;
  logic [SEL_W-1:0]        bus_sel;
  logic [NREG-1:0]         reg_we;
  logic                    a_load, g_load, sub_mode;
  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0]           g_q;
  logic [DW-1:0]           bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  rtp16_ctrl #(.NREG(NREG)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .ins_word (din[DW-1 -: IR_W]),
    .bus_sel  (bus_sel),
    .reg_we   (reg_we),
    .a_load   (a_load),
    .g_load   (g_load),
    .sub_mode (sub_mode),
    .done     (done)
  );

  rtp16_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (reg_we),
    .wdata (bus),
    .regs  (regs)
  );

  rtp16_alu #(.DW(DW)) u_alu (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .a_load   (a_load),
    .g_load   (g_load),
    .sub_mode (sub_mode),
    .bus      (bus),
    .g_q      (g_q)
  );

  always_comb begin
    if (bus_sel < SEL_W'(NREG))       bus = regs[bus_sel[RIDX_W-1:0]];
    else if (bus_sel == SEL_W'(NREG)) bus = din;
    else                               bus = g_q;
  end

  assign bus_out = bus;
  assign r0_q    = regs[0];
  assign r1_q    = regs[1];

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done); // R10
endmodule

// File: tb/rtp16_core_tb.sv
`timescale 1ns/1ps
module rtp16_core_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic [15:0] din;
  logic        done;
  logic [15:0] bus_out, r0_q, r1_q;

  int vectors = 0;
  int miscompares = 0;
  int noise = 0;
  logic [15:0] m [8];

  always #2.5 clk = ~clk;

  rtp16_core u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .din(din),
    .done(done), .bus_out(bus_out), .r0_q(r0_q), .r1_q(r1_q)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, compare 1 ns later, then let the rising edge occur
  task automatic cyc(input logic [15:0] d, input logic r,
                     input logic [15:0] eb, input logic ed, input string tag);
    @(negedge clk);
    din = d;
    run = r;
    #1;
    vectors++;
    cmp(tag, "bus",  bus_out, eb);
    cmp(tag, "done", {15'd0, done}, {15'd0, ed});
    cmp(tag, "r0",   r0_q, m[0]);
    cmp(tag, "r1",   r1_q, m[1]);
  endtask

  function automatic logic [15:0] junk();
    noise++;
    return 16'hA5C3 ^ 16'(noise * 16'h1357);
  endfunction

  function automatic logic [15:0] ins(input logic [2:0] op, input logic [2:0] x,
                                      input logic [2:0] y);
    return {op, x, y, 7'h5A};  // low bits non-zero: R3
  endfunction

  task automatic do_mov(input logic [2:0] x, input logic [2:0] y);
    logic [15:0] w = ins(3'b001, x, y);
    cyc(w, 1'b1, w, 1'b0, "R3 fetch mov");
    cyc(junk(), 1'b1, m[y], 1'b1, "R4 move");
    m[x] = m[y];
  endtask

  task automatic do_imm(input logic [2:0] x, input logic [15:0] v);
    logic [15:0] w = ins(3'b010, x, 3'd6);
    cyc(w, 1'b1, w, 1'b0, "R3 fetch imm");
    cyc(v, 1'b1, v, 1'b1, "R5 immediate");
    m[x] = v;
  endtask

  task automatic do_arith(input logic s, input logic [2:0] x, input logic [2:0] y);
    logic [15:0] w = ins(s ? 3'b100 : 3'b011, x, y);
    logic [15:0] res = s ? (m[x] - m[y]) : (m[x] + m[y]);
    string t = s ? "R7 sub" : "R6 add";
    cyc(w, 1'b1, w, 1'b0, "R3 fetch arith");
    cyc(junk(), 1'b0, m[x], 1'b0, {t, " R8 rx step"});
    cyc(junk(), 1'b1, m[y], 1'b0, {t, " R8 ry step"});
    cyc(junk(), 1'b0, res, 1'b1, {t, " R11 result"});
    m[x] = res;
  endtask

  task automatic do_nop(input logic [2:0] op);
    logic [15:0] w = ins(op, 3'd0, 3'd1);
    logic [15:0] j;
    cyc(w, 1'b1, w, 1'b0, "R9 fetch nop");
    j = junk();
    cyc(j, 1'b1, j, 1'b1, "R9 no-op");
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog timeout");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 16'h0000;
    rst_n = 1'b0;
    run   = 1'b0;
    din   = 16'h1234;
    cyc(16'h1234, 1'b0, 16'h1234, 1'b0, "R1 in reset");
    cyc(16'hBEEF, 1'b1, 16'hBEEF, 1'b0, "R1 in reset run");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(16'h0F0F, 1'b0, 16'h0F0F, 1'b0, "R1 after release");

    do_imm(3'd0, 16'h0080);
    do_imm(3'd1, 16'hFFFF);
    for (int i = 0; i < 4; i++) begin
      logic [15:0] w = ins(3'b001, 3'd0, 3'd1);
      cyc(w, 1'b0, w, 1'b0, "R2 idle run low");
    end
    do_mov(3'd2, 3'd0);
    do_arith(1'b0, 3'd0, 3'd1);   // 0x0080+0xFFFF -> 0x007F
    do_arith(1'b1, 3'd1, 3'd0);   // 0xFFFF-0x007F -> 0xFF80
    do_imm(3'd3, 16'd5);
    do_imm(3'd4, 16'd9);
    do_arith(1'b1, 3'd3, 3'd4);   // 5-9 -> 0xFFFC
    do_mov(3'd0, 3'd3);
    do_arith(1'b0, 3'd2, 3'd2);   // rx == ry doubles
    do_mov(3'd1, 3'd2);
    do_imm(3'd5, 16'h7777);
    do_arith(1'b1, 3'd5, 3'd5);   // self subtract -> 0
    do_mov(3'd0, 3'd5);
    do_imm(3'd7, 16'hFFFF);
    do_imm(3'd6, 16'h0002);
    do_arith(1'b0, 3'd7, 3'd6);   // wrap to 0x0001
    do_mov(3'd1, 3'd7);
    do_nop(3'b000);
    do_nop(3'b101);
    do_nop(3'b110);
    do_nop(3'b111);
    do_mov(3'd0, 3'd4);
    do_mov(3'd1, 3'd6);
    cyc(16'h2C00, 1'b0, 16'h2C00, 1'b0, "R2 final idle");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule